// File: doc/BRIEF.md
# Incoming Block Audit-Trail Recorder

This block sits in the memory-side path between the directory and the cache. Every memory block arriving for the cache passes through it combinationally, with tag, line index and data unchanged. When the block was fetched for a data access, the recorder writes it into a local log at the next free slot in the same cycle the cache accepts it. Each slot holds an extended tag and the block data. Blocks fetched for instructions pass through and are never logged.

When the log is full, the next data block is held back and a checkpoint request is raised. Finishing the checkpoint empties the log, and the held block then goes through and becomes the first entry of the new log.

After a rollback the block runs in replay mode. Logging stops and the cache asks for its misses by extended tag. The recorder answers from the log in order, using a read pointer that restarts at zero and moves only when the entry it points at matches the request.

Top module: `blkaudit_recorder`

## Requirements
- R1: While `rst_n` is low, at every clock edge `log_index` becomes 0, `ckpt_req` becomes 0 and `rsp_valid` becomes 0.
- R2: When no stall applies, `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle. When `out_valid` is high, `out_tag`, `out_idx` and `out_data` equal `in_tag`, `in_idx` and `in_data`.
- R3: A block with `in_is_data` = 0 is never logged and is never stalled, even when the log is full. `log_index` is unchanged by it.
- R4: Outside replay mode, a data block (`in_is_data` = 1) that completes the handshake (`in_valid` and `out_ready` both high, log not full) is stored at slot `log_index`, and `log_index` rises by one at the next edge.
- R5: When `log_index` equals DEPTH, an offered data block outside replay mode gives `out_valid` = 0 and `in_ready` = 0. `ckpt_req` goes high at the next edge and stays high until `ckpt_done`.
- R6: A `ckpt_done` pulse empties the log. At the next edge `ckpt_req` is 0 and `log_index` is 0, or 1 if a data block was accepted in that same cycle, in which case that block is stored at slot 0.
- R7: While `replay_mode` is high, data blocks are forwarded like instruction blocks: nothing is logged, nothing stalls and no checkpoint is requested.
- R8: A `replay_start` pulse sets the replay read pointer to slot 0 and produces no response in that cycle.
- R9: A request (`rq_valid`) without `replay_start` gives `rsp_valid` = 1 one cycle later. `rsp_hit` is 1 when the read pointer is below `log_index` and the extended tag at the pointer equals `rq_ext_tag`, where the extended tag is {tag, line index} with the tag in the upper bits. On a hit, `rsp_data` is the logged data and the pointer moves to the next slot.
- R10: A request that does not match, or that finds the pointer at or beyond `log_index`, gives `rsp_hit` = 0 and `rsp_data` = 0, and leaves the pointer in place. A later matching request still returns the entry the pointer was already on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming block offered by the directory |
| in_ready | output | 1 | Incoming block accepted this cycle |
| in_is_data | input | 1 | 1 for a data fetch, 0 for an instruction fetch |
| in_tag | input | TAG_W | Address tag of the block |
| in_idx | input | IDX_W | Cache line index receiving the block |
| in_data | input | DATA_W | Block contents |
| out_valid | output | 1 | Block presented to the cache |
| out_ready | input | 1 | Cache accepts the block |
| out_tag | output | TAG_W | Forwarded tag |
| out_idx | output | IDX_W | Forwarded line index |
| out_data | output | DATA_W | Forwarded contents |
| log_index | output | $clog2(DEPTH+1) | Next free log slot, equal to the number of logged blocks |
| ckpt_req | output | 1 | Log full, checkpoint needed |
| ckpt_done | input | 1 | One-cycle pulse: checkpoint finished |
| replay_mode | input | 1 | Recovery in progress, logging off |
| replay_start | input | 1 | One-cycle pulse: rewind replay pointer |
| rq_valid | input | 1 | Replay request |
| rq_ext_tag | input | TAG_W+IDX_W | Requested extended tag {tag, line index} |
| rsp_valid | output | 1 | Replay response present |
| rsp_hit | output | 1 | Entry at pointer matched |
| rsp_data | output | DATA_W | Logged data on hit, else zero |

## Verification
The embedded properties assume several things about the inputs. `ckpt_done` and `replay_start` arrive as single-cycle pulses, no checkpoint completes while replay mode is active, and replay requests are issued only in replay mode. The stimulus keeps to all of these. It raises `ckpt_done` only outside replay, it drops each pulse after one cycle, and it sends requests only after setting `replay_mode` and rewinding with `replay_start`. Random traffic varies `out_ready` and the data/instruction mix. The stimulus also holds a data block at the full log for several cycles, so the stall and the request hold are exercised before the checkpoint releases the block.

// File: rtl/blkaudit_pkg.sv
// Shared defaults for the incoming-block audit-trail recorder.
// Assumes: consumers take these as parameter defaults only.
package blkaudit_pkg;
    localparam int DEF_TAG_W  = 20;
    localparam int DEF_IDX_W  = 6;
    localparam int DEF_DATA_W = 64;
    localparam int DEF_DEPTH  = 64;
endpackage

// File: rtl/blkaudit_log_ctrl.sv
// Write-side control of the audit log: next-free index, full detection,
// stall of data blocks at a full log and the checkpoint request.
// Assumes: ckpt_done is a one-cycle pulse and is not raised during replay.
module blkaudit_log_ctrl #(
    parameter int DEPTH = blkaudit_pkg::DEF_DEPTH,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_beat,
    input  logic          fwd_ready,
    input  logic          replay_mode,
    input  logic          ckpt_done,
    output logic          stall,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [CW-1:0] count,
    output logic          ckpt_req
);
    logic full;

    // Full when every slot holds a block of the current epoch.
    assign full    = (count == CW'(DEPTH));
    // Hold back data blocks only when logging is on and no slot is free.
    assign stall   = data_beat & ~replay_mode & full;
    // Log a data block when the cache takes it and a slot is free.
    assign wr_en   = data_beat & ~replay_mode & ~full & fwd_ready;
    // A block accepted with ckpt_done opens the new epoch at slot 0.
    assign wr_addr = ckpt_done ? '0 : count[AW-1:0];

    // Next-free index: cleared by checkpoint, advanced by each logged block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (ckpt_done) begin
            count <= wr_en ? CW'(1) : '0;
        end else if (wr_en) begin
            count <= count + CW'(1);
        end
    end

    // Checkpoint request: set by a stalled block, held until completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ckpt_req <= 1'b0;
        end else if (ckpt_done) begin
            ckpt_req <= 1'b0;
        end else if (stall) begin
            ckpt_req <= 1'b1;
        end
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_req && !ckpt_done |=> ckpt_req);
    // R6
    ckpt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_done |=> !ckpt_req && count <= CW'(1));
    // R7
    replay_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay_mode && !ckpt_done |=> count == $past(count));
endmodule

// File: rtl/blkaudit_store.sv
// Log storage: one write port, one combinational read port.
// Assumes: addresses are below DEPTH whenever the port is used.
module blkaudit_store #(
    parameter int W     = 90,
    parameter int DEPTH = blkaudit_pkg::DEF_DEPTH,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_word,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_word
);
    logic [W-1:0] slots [DEPTH];

    // Write one entry per accepted data block.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_addr] <= wr_word;
        end
    end

    // Read the entry at the replay pointer.
    assign rd_word = slots[rd_addr];
endmodule

// File: rtl/blkaudit_replay.sv
// Replay side: in-order read pointer that moves only on a matching entry,
// registered response with hit flag and data.
// Assumes: requests are made only in replay mode; replay_start is a pulse.
module blkaudit_replay #(
    parameter int EXT_W  = 26,
    parameter int DATA_W = 64,
    parameter int DEPTH  = blkaudit_pkg::DEF_DEPTH,
    parameter int AW     = $clog2(DEPTH),
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rq_valid,
    input  logic [EXT_W-1:0]  rq_ext,
    input  logic [CW-1:0]     count,
    input  logic [EXT_W-1:0]  entry_ext,
    input  logic [DATA_W-1:0] entry_data,
    output logic [AW-1:0]     rd_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data
);
    logic [CW-1:0] rd_ptr;
    logic          avail;
    logic          match;
    logic          take;

    // Entry at the pointer is live and carries the requested extended tag.
    assign avail   = rd_ptr < count;
    assign match   = avail && (entry_ext == rq_ext);
    assign take    = rq_valid & ~start;
    assign rd_addr = rd_ptr[AW-1:0];

    // Read pointer: rewound by start, advanced only by a served match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (start) begin
            rd_ptr <= '0;
        end else if (rq_valid && match) begin
            rd_ptr <= rd_ptr + CW'(1);
        end
    end

    // Registered response: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= take;
            rsp_hit   <= take & match;
            rsp_data  <= (take && match) ? entry_data : '0;
        end
    end

    // R8
    rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> rd_ptr == '0 && !rsp_valid);
    // R9
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid && !start |=> rsp_valid);
    // R10
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> rd_ptr == $past(rd_ptr));
    // R9
    hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rd_ptr == $past(rd_ptr) + CW'(1));
endmodule

// File: rtl/blkaudit_recorder.sv
// Incoming-block audit-trail recorder. Forwards every block to the cache
// combinationally, logs data blocks in the same cycle, stalls data blocks
// at a full log while requesting a checkpoint, and serves logged blocks in
// order during replay.
// Assumes: ckpt_done only outside replay; rq_valid only in replay mode.
module blkaudit_recorder #(
    parameter int TAG_W  = blkaudit_pkg::DEF_TAG_W,
    parameter int IDX_W  = blkaudit_pkg::DEF_IDX_W,
    parameter int DATA_W = blkaudit_pkg::DEF_DATA_W,
    parameter int DEPTH  = blkaudit_pkg::DEF_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic                       in_is_data,
    input  logic [TAG_W-1:0]           in_tag,
    input  logic [IDX_W-1:0]           in_idx,
    input  logic [DATA_W-1:0]          in_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [TAG_W-1:0]           out_tag,
    output logic [IDX_W-1:0]           out_idx,
    output logic [DATA_W-1:0]          out_data,
    output logic [$clog2(DEPTH+1)-1:0] log_index,
    output logic                       ckpt_req,
    input  logic                       ckpt_done,
    input  logic                       replay_mode,
    input  logic                       replay_start,
    input  logic                       rq_valid,
    input  logic [TAG_W+IDX_W-1:0]     rq_ext_tag,
    output logic                       rsp_valid,
    output logic                       rsp_hit,
    output logic [DATA_W-1:0]          rsp_data
);
    localparam int EXT_W = TAG_W + IDX_W;
    localparam int WORD  = EXT_W + DATA_W;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    logic            stall;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [AW-1:0]   rd_addr;
    logic [WORD-1:0] rd_word;
    logic [WORD-1:0] wr_word;

    // Forward path: pass-through unless a data block meets a full log.
    assign out_valid = in_valid & ~stall;
    assign in_ready  = out_ready & ~stall;
    assign out_tag   = in_tag;
    assign out_idx   = in_idx;
    assign out_data  = in_data;
    // Log word: extended tag {tag, line index} above the data.
    assign wr_word   = {in_tag, in_idx, in_data};

    blkaudit_log_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_beat  (in_valid & in_is_data),
        .fwd_ready  (out_ready),
        .replay_mode(replay_mode),
        .ckpt_done  (ckpt_done),
        .stall      (stall),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .count      (log_index),
        .ckpt_req   (ckpt_req)
    );

    blkaudit_store #(.W(WORD), .DEPTH(DEPTH), .AW(AW)) store_i (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_word(wr_word),
        .rd_addr(rd_addr),
        .rd_word(rd_word)
    );

    blkaudit_replay #(.EXT_W(EXT_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
                      .AW(AW), .CW(CW)) replay_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (replay_start),
        .rq_valid  (rq_valid),
        .rq_ext    (rq_ext_tag),
        .count     (log_index),
        .entry_ext (rd_word[WORD-1:DATA_W]),
        .entry_data(rd_word[DATA_W-1:0]),
        .rd_addr   (rd_addr),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_data  (rsp_data)
    );

    // R2
    fwd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);
    // R3
    instr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_is_data |-> out_valid);
    // R3
    instr_nolog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_is_data && !ckpt_done |=> log_index == $past(log_index));
    // R5
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_is_data && !replay_mode && log_index == CW'(DEPTH)
        |-> !out_valid && !in_ready);
    // R4
    log_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_is_data && out_ready && !replay_mode && !ckpt_done
        && log_index < CW'(DEPTH) |=> log_index == $past(log_index) + CW'(1));
endmodule

// File: tb/blkaudit_recorder_tb_top.sv
`timescale 1ns/1ps
module blkaudit_recorder_tb_top;
    localparam int TAG_W  = blkaudit_pkg::DEF_TAG_W;
    localparam int IDX_W  = blkaudit_pkg::DEF_IDX_W;
    localparam int DATA_W = blkaudit_pkg::DEF_DATA_W;
    localparam int DEPTH  = blkaudit_pkg::DEF_DEPTH;
    localparam int EXT_W  = TAG_W + IDX_W;
    localparam int CW     = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_is_data = 0, out_ready = 0;
    logic [TAG_W-1:0]  in_tag = '0;
    logic [IDX_W-1:0]  in_idx = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic ckpt_done = 0, replay_mode = 0, replay_start = 0, rq_valid = 0;
    logic [EXT_W-1:0]  rq_ext_tag = '0;
    logic in_ready, out_valid, ckpt_req, rsp_valid, rsp_hit;
    logic [TAG_W-1:0]  out_tag;
    logic [IDX_W-1:0]  out_idx;
    logic [DATA_W-1:0] out_data, rsp_data;
    logic [CW-1:0]     log_index;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    int m_cnt = 0;
    int m_rd = 0;
    bit m_req = 0;
    bit m_rv = 0, m_rh = 0;
    logic [DATA_W-1:0] m_rdat = '0;
    logic [EXT_W-1:0]  m_ext [DEPTH];
    logic [DATA_W-1:0] m_dat [DEPTH];

    always #4 clk = ~clk;

    blkaudit_recorder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_is_data(in_is_data), .in_tag(in_tag), .in_idx(in_idx),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_tag(out_tag), .out_idx(out_idx), .out_data(out_data),
        .log_index(log_index), .ckpt_req(ckpt_req), .ckpt_done(ckpt_done),
        .replay_mode(replay_mode), .replay_start(replay_start),
        .rq_valid(rq_valid), .rq_ext_tag(rq_ext_tag), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", rq, act, exp, $time);
        end
    endtask

    // compare outputs with the model, then advance the model over the next edge
    task automatic tick();
        bit st, lg;
        string fr;
        #1;
        st = in_valid && in_is_data && !replay_mode && (m_cnt == DEPTH);
        fr = st ? "R5 stall" : (!in_is_data ? "R3 instr" : (replay_mode ? "R7 replay fwd" : "R2 fwd"));
        chk(out_valid == (in_valid && !st), {fr, " out_valid"}, 64'(out_valid), 64'(in_valid && !st));
        chk(in_ready == (out_ready && !st), {fr, " in_ready"}, 64'(in_ready), 64'(out_ready && !st));
        if (out_valid) begin
            chk(out_tag == in_tag && out_idx == in_idx, "R2 out tag/idx",
                64'({out_tag, out_idx}), 64'({in_tag, in_idx}));
            chk(out_data == in_data, "R2 out_data", 64'(out_data), 64'(in_data));
        end
        chk(log_index == CW'(m_cnt), !rst_n ? "R1 log_index" : (replay_mode ? "R7 log_index" : "R4 log_index"),
            64'(log_index), 64'(m_cnt));
        chk(ckpt_req == m_req, !rst_n ? "R1 ckpt_req" : "R5/R6 ckpt_req", 64'(ckpt_req), 64'(m_req));
        chk(rsp_valid == m_rv, !rst_n ? "R1 rsp_valid" : "R9 rsp_valid", 64'(rsp_valid), 64'(m_rv));
        if (m_rv) begin
            chk(rsp_hit == m_rh, m_rh ? "R9 rsp_hit" : "R10 rsp_hit", 64'(rsp_hit), 64'(m_rh));
            chk(rsp_data == m_rdat, m_rh ? "R9 rsp_data" : "R10 rsp_data", 64'(rsp_data), 64'(m_rdat));
        end
        // model update for the coming edge
        if (!rst_n) begin
            m_cnt = 0; m_rd = 0; m_req = 0; m_rv = 0; m_rh = 0; m_rdat = '0;
        end else begin
            bit h;
            h = 0;
            if (rq_valid && !replay_start)
                h = (m_rd < m_cnt) && (m_ext[m_rd] == rq_ext_tag);
            m_rv = rq_valid && !replay_start;
            m_rh = h;
            m_rdat = h ? m_dat[m_rd] : '0;
            if (replay_start) m_rd = 0;
            else if (h) m_rd++;
            lg = in_valid && in_is_data && !replay_mode && (m_cnt < DEPTH) && out_ready;
            if (ckpt_done) begin
                m_req = 0;
                m_cnt = 0;
            end else if (st) begin
                m_req = 1;
            end
            if (lg) begin
                m_ext[m_cnt] = {in_tag, in_idx};
                m_dat[m_cnt] = in_data;
                m_cnt++;
            end
        end
        @(negedge clk);
    endtask

    task automatic offer(input bit v, input bit d, input bit rdy);
        in_valid = v; in_is_data = d; out_ready = rdy;
        in_tag = TAG_W'($urandom); in_idx = IDX_W'($urandom);
        in_data = {$urandom, $urandom};
    endtask

    task automatic traffic(input int n, input int dpct, input int rpct);
        for (int i = 0; i < n; i++) begin
            offer(($urandom % 100) < 75, ($urandom % 100) < dpct, ($urandom % 100) < rpct);
            tick();
        end
        offer(0, 0, 0);
    endtask

    task automatic checkpoint();
        ckpt_done = 1; tick(); ckpt_done = 0;
    endtask

    task automatic request(input bit want_hit);
        logic [EXT_W-1:0] e;
        rq_valid = 1;
        e = (m_rd < DEPTH) ? m_ext[m_rd] : EXT_W'($urandom);
        rq_ext_tag = want_hit ? e : (e ^ EXT_W'(1));
        tick();
        rq_valid = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: reset state
        repeat (2) tick();
        rst_n = 1;
        tick();
        // R2 R3 R4: mixed traffic with back-pressure
        traffic(40, 50, 60);
        checkpoint();
        traffic(30, 100, 50);
        // R5: fill the log, then hold a data block at the full log
        while (m_cnt < DEPTH) begin offer(1, 1, 1); tick(); end
        offer(1, 1, 1);
        repeat (4) tick();
        // R3: instruction block passes while full
        offer(1, 0, 1); tick();
        // R6: release with the stalled data block still offered
        offer(1, 1, 1);
        checkpoint();
        tick();
        offer(0, 0, 0);
        tick();
        // checkpoint while empty-ish and random traffic
        traffic(20, 80, 70);
        checkpoint();
        // known epoch for replay
        for (int i = 0; i < 6; i++) begin offer(1, 1, 1); tick(); end
        offer(0, 0, 0); tick();
        // R7 R8: enter replay and rewind
        replay_mode = 1; tick();
        replay_start = 1; tick(); replay_start = 0;
        // R9 R10
        request(1);
        request(0);
        request(1);
        offer(1, 1, 1); tick(); offer(0, 0, 0);
        request(0);
        repeat (4) request(1);
        request(1);       // exhausted: R10
        request(0);
        tick();
        // R8: rewind and replay again, request blocked by start
        replay_start = 1; rq_valid = 1; rq_ext_tag = m_ext[0]; tick();
        replay_start = 0; rq_valid = 0;
        request(1);
        traffic(20, 100, 80);
        for (int i = 0; i < 30; i++) request(($urandom % 2) == 0);
        replay_mode = 0; tick();
        tick();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule